// File: doc/BRIEF.md
# Prioritized Processor Interrupt Resolver

This block turns every interrupt source a processor core sees into a single registered request and the trap type the core should take. External devices present a vector of level requests; software holds its own bit register, in which two positions are timer events. A single vectored interrupt channel can be raised and lowered by an interrupt controller. It carries a source number, and the block latches that number into three data words for the trap handler to read.

Each cycle the block selects a winner. A pending vectored interrupt wins over all level requests and yields the vector trap type. Otherwise it scans the merged level requests above the current processor interrupt level (PIL), highest first, and encodes the winner as an external-interrupt trap type. If the core is already inside a trap of a higher external-interrupt type, the new request is held back and the outputs keep their previous values. With interrupts globally disabled, or nothing eligible, the request drops. Trap entry, the trap stack and software writes to the soft register happen elsewhere.

Top module: `irq_resolver`

## Requirements
- R1: The merged level vector is `lvl_ext` OR-ed with `soft_int[15:0]`, except that soft bit 0 (tick timer) and soft bit 16 (system timer) never act as levels on their own positions.
- R2: When soft bit 0 or soft bit 16 is set, level 14 is treated as pending.
- R3: Only levels strictly greater than `pil` are eligible, and the highest eligible level wins.
- R4: A winning level N produces `irq_req`=1 and `trap_type`=0x40|N on the clock edge that samples the inputs, with no further delay. Whenever `irq_req` is 0, `trap_type` is 0.
- R5: While the vectored interrupt is pending, `irq_req`=1 and `trap_type`=0x60, regardless of levels, `pil` or `glb_en`.
- R6: With no vectored interrupt pending, if `glb_en` is 0 or no level is eligible, `irq_req` and `trap_type` clear to 0.
- R7: If `trap_lvl`>0, the upper five bits of `act_tt` equal those of 0x40, and `act_tt` is numerically greater than the new level trap type, then `irq_req` and `trap_type` keep their previous values. An equal `act_tt`, an `act_tt` outside the 0x40 to 0x4F group, or `trap_lvl`=0 does not hold them back.
- R8: An accepted raise loads `vec_data0`=(0x1F<<6)|`vec_src`, and `vec_data1`=`vec_data2`=0.
- R9: A raise while the vectored interrupt is already pending has no effect on the data words.
- R10: `vec_lower` clears the pending vectored interrupt. On the same edge, the request is judged from the levels alone. The data words keep their values.
- R11: When `vec_raise` and `vec_lower` are asserted in the same cycle, lower wins: nothing becomes pending and the data words are unchanged.
- R12: A synchronous `rst` clears `irq_req`, `trap_type`, the pending state and all data words to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lvl_ext | input | 16 | External interrupt level requests, bit N = level N |
| soft_int | input | 17 | Software interrupt bits; bit 0 tick timer, bit 16 system timer |
| pil | input | 4 | Processor interrupt level |
| glb_en | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap level |
| act_tt | input | 9 | Trap type of the trap currently active |
| vec_raise | input | 1 | Raise strobe of the vectored interrupt |
| vec_lower | input | 1 | Lower strobe of the vectored interrupt |
| vec_src | input | 6 | Source number carried by a raise |
| irq_req | output | 1 | Interrupt request to the core |
| trap_type | output | 9 | Selected trap type |
| vec_data0 | output | 64 | Vectored data word 0 |
| vec_data1 | output | 64 | Vectored data word 1 |
| vec_data2 | output | 64 | Vectored data word 2 |

## Verification
Two events can share one cycle. The vectored channel can be raised or lowered on the same edge that the level inputs change. Raise and lower can also both be asserted together. The bench lowers the vector on an edge where a level 15 request is present and expects 0x4F at once, not a cleared request. It then strobes raise and lower together after a previous vector was lowered, and expects no vector trap type and an unchanged `vec_data0`. The nesting guard is driven from an already asserted state, so a held request can be told apart from a cleared one.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
   // which rule set the next request
   typedef enum logic [1:0] {
      PICK_NONE   = 2'd0,
      PICK_LEVEL  = 2'd1,
      PICK_VECTOR = 2'd2,
      PICK_HOLD   = 2'd3
   } pick_e;

   function automatic int unsigned lvl_bits(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/irq_level_sel.sv
module irq_level_sel
   import irq_res_pkg::*;
#(
   parameter int unsigned NUM_LEVELS = 16,
   parameter int unsigned SOFT_W     = 17,
   parameter int unsigned TICK_POS   = 0,
   parameter int unsigned STICK_POS  = 16,
   parameter int unsigned TIMER_LVL  = 14,
   localparam int unsigned LVL_W     = lvl_bits(NUM_LEVELS)
) (
   input  logic [NUM_LEVELS-1:0] lvl_ext,
   input  logic [SOFT_W-1:0]     soft_int,
   input  logic [LVL_W-1:0]      pil,
   output logic                  any_elig,
   output logic [LVL_W-1:0]      win_lvl
);
   logic                  timer_hit;
   logic [NUM_LEVELS-1:0] merged;
   logic [NUM_LEVELS-1:0] elig;

   if (SOFT_W < NUM_LEVELS) begin : g_bad_soft
      $error("irq_level_sel: soft register narrower than level vector");
   end
   if (TICK_POS >= SOFT_W || STICK_POS >= SOFT_W) begin : g_bad_tpos
      $error("irq_level_sel: timer bit outside soft register");
   end
   if (TIMER_LVL >= NUM_LEVELS) begin : g_bad_tlvl
      $error("irq_level_sel: timer level outside level range");
   end

   assign timer_hit = soft_int[TICK_POS] | soft_int[STICK_POS];

   for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_lvl
      logic soft_bit;
      logic fold_bit;
      if (i == TICK_POS || i == STICK_POS) begin : g_tmr
         assign soft_bit = 1'b0;
      end else begin : g_sw
         assign soft_bit = soft_int[i];
      end
      if (i == TIMER_LVL) begin : g_fold
         assign fold_bit = timer_hit;
      end else begin : g_nofold
         assign fold_bit = 1'b0;
      end
      assign merged[i] = lvl_ext[i] | soft_bit | fold_bit;
      assign elig[i]   = merged[i] && (LVL_W'(i) > pil);
   end

   // ascending walk, last hit is the highest level
   always_comb begin
      any_elig = 1'b0;
      win_lvl  = '0;
      for (int i = 0; i < NUM_LEVELS; i++) begin
         if (elig[i]) begin
            any_elig = 1'b1;
            win_lvl  = LVL_W'(i);
         end
      end
   end
endmodule

// File: rtl/irq_nest_gate.sv
module irq_nest_gate #(
   parameter int unsigned TT_W       = 9,
   parameter int unsigned TL_W       = 3,
   parameter int unsigned NUM_LEVELS = 16,
   parameter int unsigned EXT_BASE   = 'h40
) (
   input  logic [TL_W-1:0] trap_lvl,
   input  logic [TT_W-1:0] act_tt,
   input  logic [TT_W-1:0] new_tt,
   output logic            hold_off
);
   localparam logic [TT_W-1:0] GRP_MASK = ~TT_W'(NUM_LEVELS - 1);
   localparam logic [TT_W-1:0] GRP_BASE = TT_W'(EXT_BASE);

   logic in_group;
   logic outranks;

   assign in_group = (act_tt & GRP_MASK) == GRP_BASE;
   assign outranks = act_tt > new_tt;
   assign hold_off = (trap_lvl != '0) && in_group && outranks;
endmodule

// File: rtl/irq_vec_latch.sv
module irq_vec_latch #(
   parameter int unsigned SRC_W    = 6,
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned N_WORDS  = 3,
   parameter int unsigned MARK     = 'h1F,
   parameter int unsigned MARK_SH  = 6
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       raise,
   input  logic                       lower,
   input  logic [SRC_W-1:0]           src,
   output logic                       pend_n,
   output logic                       pend_q,
   output logic [N_WORDS*DATA_W-1:0]  words
);
   logic accept;

   if (SRC_W > MARK_SH) begin : g_bad_src
      $error("irq_vec_latch: source number overlaps marker field");
   end

   assign accept = raise && !lower && !pend_q;

   always_comb begin
      pend_n = pend_q;
      if (lower) begin
         pend_n = 1'b0;
      end else if (raise) begin
         pend_n = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= 1'b0;
      end else begin
         pend_q <= pend_n;
      end
   end

   for (genvar k = 0; k < N_WORDS; k++) begin : g_word
      logic [DATA_W-1:0] load_val;
      logic [DATA_W-1:0] word_q;
      if (k == 0) begin : g_first
         assign load_val = (DATA_W'(MARK) << MARK_SH) | DATA_W'(src);
      end else begin : g_rest
         assign load_val = '0;
      end
      always_ff @(posedge clk) begin
         if (rst) begin
            word_q <= '0;
         end else if (accept) begin
            word_q <= load_val;
         end
      end
      assign words[k*DATA_W +: DATA_W] = word_q;
   end
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
   import irq_res_pkg::*;
#(
   parameter int unsigned NUM_LEVELS = 16,
   parameter int unsigned SOFT_W     = 17,
   parameter int unsigned TICK_POS   = 0,
   parameter int unsigned STICK_POS  = 16,
   parameter int unsigned TIMER_LVL  = 14,
   parameter int unsigned TT_W       = 9,
   parameter int unsigned TL_W       = 3,
   parameter int unsigned SRC_W      = 6,
   parameter int unsigned DATA_W     = 64,
   parameter int unsigned EXT_BASE   = 'h40,
   parameter int unsigned VEC_TT     = 'h60,
   localparam int unsigned LVL_W     = lvl_bits(NUM_LEVELS),
   localparam int unsigned N_WORDS   = 3
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [NUM_LEVELS-1:0] lvl_ext,
   input  logic [SOFT_W-1:0]     soft_int,
   input  logic [LVL_W-1:0]      pil,
   input  logic                  glb_en,
   input  logic [TL_W-1:0]       trap_lvl,
   input  logic [TT_W-1:0]       act_tt,
   input  logic                  vec_raise,
   input  logic                  vec_lower,
   input  logic [SRC_W-1:0]      vec_src,
   output logic                  irq_req,
   output logic [TT_W-1:0]       trap_type,
   output logic [DATA_W-1:0]     vec_data0,
   output logic [DATA_W-1:0]     vec_data1,
   output logic [DATA_W-1:0]     vec_data2
);
   if ((EXT_BASE % NUM_LEVELS) != 0) begin : g_bad_base
      $error("irq_resolver: level base code not aligned to level count");
   end
   if (EXT_BASE + NUM_LEVELS > (1 << TT_W) || VEC_TT >= (1 << TT_W)) begin : g_bad_tt
      $error("irq_resolver: trap type codes exceed trap type width");
   end

   logic                      any_elig;
   logic [LVL_W-1:0]          win_lvl;
   logic [TT_W-1:0]           lvl_tt;
   logic                      hold_off;
   logic                      vec_pend_n;
   logic                      vec_pend_q;
   logic [N_WORDS*DATA_W-1:0] words;
   pick_e                     pick;
   logic                      req_q;
   logic [TT_W-1:0]           tt_q;
   logic                      req_n;
   logic [TT_W-1:0]           tt_n;

   irq_level_sel #(
      .NUM_LEVELS (NUM_LEVELS),
      .SOFT_W     (SOFT_W),
      .TICK_POS   (TICK_POS),
      .STICK_POS  (STICK_POS),
      .TIMER_LVL  (TIMER_LVL)
   ) u_sel (
      .lvl_ext  (lvl_ext),
      .soft_int (soft_int),
      .pil      (pil),
      .any_elig (any_elig),
      .win_lvl  (win_lvl)
   );

   assign lvl_tt = TT_W'(EXT_BASE) | TT_W'(win_lvl);

   irq_nest_gate #(
      .TT_W       (TT_W),
      .TL_W       (TL_W),
      .NUM_LEVELS (NUM_LEVELS),
      .EXT_BASE   (EXT_BASE)
   ) u_gate (
      .trap_lvl (trap_lvl),
      .act_tt   (act_tt),
      .new_tt   (lvl_tt),
      .hold_off (hold_off)
   );

   irq_vec_latch #(
      .SRC_W   (SRC_W),
      .DATA_W  (DATA_W),
      .N_WORDS (N_WORDS)
   ) u_vec (
      .clk    (clk),
      .rst    (rst),
      .raise  (vec_raise),
      .lower  (vec_lower),
      .src    (vec_src),
      .pend_n (vec_pend_n),
      .pend_q (vec_pend_q),
      .words  (words)
   );

   always_comb begin
      if (vec_pend_n) begin
         pick = PICK_VECTOR;
      end else if (!glb_en || !any_elig) begin
         pick = PICK_NONE;
      end else if (hold_off) begin
         pick = PICK_HOLD;
      end else begin
         pick = PICK_LEVEL;
      end
   end

   always_comb begin
      unique case (pick)
         PICK_VECTOR: begin req_n = 1'b1;  tt_n = TT_W'(VEC_TT); end
         PICK_LEVEL:  begin req_n = 1'b1;  tt_n = lvl_tt;        end
         PICK_HOLD:   begin req_n = req_q; tt_n = tt_q;          end
         default:     begin req_n = 1'b0;  tt_n = '0;            end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         req_q <= 1'b0;
         tt_q  <= '0;
      end else begin
         req_q <= req_n;
         tt_q  <= tt_n;
      end
   end

   assign irq_req   = req_q;
   assign trap_type = tt_q;
   assign vec_data0 = words[0*DATA_W +: DATA_W];
   assign vec_data1 = words[1*DATA_W +: DATA_W];
   assign vec_data2 = words[2*DATA_W +: DATA_W];
endmodule

// File: rtl/irq_resolver_chk.sv
module irq_resolver_chk #(
   parameter int unsigned TT_W       = 9,
   parameter int unsigned SRC_W      = 6,
   parameter int unsigned DATA_W     = 64,
   parameter int unsigned NUM_LEVELS = 16,
   parameter int unsigned EXT_BASE   = 'h40,
   parameter int unsigned VEC_TT     = 'h60
) (
   input logic              clk,
   input logic              rst,
   input logic              glb_en,
   input logic              vec_raise,
   input logic              vec_lower,
   input logic [SRC_W-1:0]  vec_src,
   input logic              vec_pend,
   input logic              irq_req,
   input logic [TT_W-1:0]   trap_type,
   input logic [DATA_W-1:0] vec_data0,
   input logic [DATA_W-1:0] vec_data1,
   input logic [DATA_W-1:0] vec_data2
);
   localparam logic [TT_W-1:0] GRP_MASK = ~TT_W'(NUM_LEVELS - 1);

   AST_VEC_WINS: assert property (@(posedge clk) disable iff (rst)
      (vec_raise && !vec_lower) |=> (irq_req && trap_type == TT_W'(VEC_TT))); // R5

   AST_VEC_FORMAT: assert property (@(posedge clk) disable iff (rst)
      (vec_raise && !vec_lower && !vec_pend) |=>
         (vec_data0 == ((DATA_W'('h1F) << 6) | DATA_W'($past(vec_src))))); // R8

   AST_WORDS_ZERO: assert property (@(posedge clk) disable iff (rst)
      (vec_data1 == '0) && (vec_data2 == '0)); // R8

   AST_VEC_IGNORE: assert property (@(posedge clk) disable iff (rst)
      (vec_pend && vec_raise) |=> $stable(vec_data0)); // R9

   AST_LOWER_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (vec_lower && !glb_en) |=> (!irq_req && trap_type == '0)); // R10

   AST_OFF_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (!glb_en && !vec_pend && !vec_raise) |=> (!irq_req && trap_type == '0)); // R6

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
      !irq_req |-> (trap_type == '0)); // R4

   AST_LVL_GROUP: assert property (@(posedge clk) disable iff (rst)
      (irq_req && trap_type != TT_W'(VEC_TT)) |-> ((trap_type & GRP_MASK) == TT_W'(EXT_BASE))); // R4
endmodule

bind irq_resolver irq_resolver_chk #(
   .TT_W       (TT_W),
   .SRC_W      (SRC_W),
   .DATA_W     (DATA_W),
   .NUM_LEVELS (NUM_LEVELS),
   .EXT_BASE   (EXT_BASE),
   .VEC_TT     (VEC_TT)
) chk_i (
   .clk       (clk),
   .rst       (rst),
   .glb_en    (glb_en),
   .vec_raise (vec_raise),
   .vec_lower (vec_lower),
   .vec_src   (vec_src),
   .vec_pend  (vec_pend_q),
   .irq_req   (irq_req),
   .trap_type (trap_type),
   .vec_data0 (vec_data0),
   .vec_data1 (vec_data1),
   .vec_data2 (vec_data2)
);

// File: tb/irq_resolver_tb_top.sv
`timescale 1ns/1ps
module irq_resolver_tb_top;
   logic        clk = 1'b0;
   logic        rst;
   logic [15:0] lvl_ext;
   logic [16:0] soft_int;
   logic [3:0]  pil;
   logic        glb_en;
   logic [2:0]  trap_lvl;
   logic [8:0]  act_tt;
   logic        vec_raise;
   logic        vec_lower;
   logic [5:0]  vec_src;
   logic        irq_req;
   logic [8:0]  trap_type;
   logic [63:0] vec_data0;
   logic [63:0] vec_data1;
   logic [63:0] vec_data2;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   irq_resolver dut_i (
      .clk(clk), .rst(rst), .lvl_ext(lvl_ext), .soft_int(soft_int), .pil(pil),
      .glb_en(glb_en), .trap_lvl(trap_lvl), .act_tt(act_tt),
      .vec_raise(vec_raise), .vec_lower(vec_lower), .vec_src(vec_src),
      .irq_req(irq_req), .trap_type(trap_type),
      .vec_data0(vec_data0), .vec_data1(vec_data1), .vec_data2(vec_data2)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk_out(input string rq, input logic e_req, input logic [8:0] e_tt);
      n_chk++;
      if (irq_req !== e_req || trap_type !== e_tt) begin
         n_fail++;
         $display("FAIL %s: req=%0b tt=0x%0h expected req=%0b tt=0x%0h",
                  rq, irq_req, trap_type, e_req, e_tt);
      end
   endtask

   task automatic chk_data(input string rq, input logic [63:0] e0);
      n_chk++;
      if (vec_data0 !== e0 || vec_data1 !== 64'h0 || vec_data2 !== 64'h0) begin
         n_fail++;
         $display("FAIL %s: data=0x%0h/0x%0h/0x%0h expected 0x%0h/0/0",
                  rq, vec_data0, vec_data1, vec_data2, e0);
      end
   endtask

   task automatic set_lv(input logic [15:0] e, input logic [16:0] s, input logic [3:0] p,
                         input logic en);
      lvl_ext = e; soft_int = s; pil = p; glb_en = en;
   endtask

   task automatic t_reset();
      rst = 1'b1; set_lv('0, '0, '0, 1'b0);
      trap_lvl = '0; act_tt = '0; vec_raise = 0; vec_lower = 0; vec_src = '0;
      tick(); tick();
      rst = 1'b0;
      chk_out("R12 reset", 1'b0, 9'h0);
      chk_data("R12 reset", 64'h0);
   endtask

   task automatic t_levels();
      set_lv(16'h0020, '0, 4'd0, 1'b1); tick();
      chk_out("R4 single level 5", 1'b1, 9'h045);
      set_lv(16'h1208, '0, 4'd0, 1'b1); tick();
      chk_out("R3 highest of 3,9,12", 1'b1, 9'h04C);
      set_lv(16'h1000, '0, 4'd12, 1'b1); tick();
      chk_out("R3 level equal to pil", 1'b0, 9'h0);
      pil = 4'd11; tick();
      chk_out("R3 level above pil", 1'b1, 9'h04C);
      set_lv(16'h0000, 17'h00080, 4'd0, 1'b1); tick();
      chk_out("R1 soft bit 7", 1'b1, 9'h047);
      set_lv(16'h0004, 17'h00800, 4'd0, 1'b1); tick();
      chk_out("R1 soft 11 over ext 2", 1'b1, 9'h04B);
   endtask

   task automatic t_timers();
      set_lv('0, 17'h00001, 4'd0, 1'b1); tick();
      chk_out("R2 tick timer to 14", 1'b1, 9'h04E);
      set_lv('0, 17'h10000, 4'd13, 1'b1); tick();
      chk_out("R2 system timer to 14", 1'b1, 9'h04E);
      pil = 4'd14; tick();
      chk_out("R2 timer masked by pil 14", 1'b0, 9'h0);
      set_lv('0, 17'h00001, 4'd14, 1'b1); tick();
      chk_out("R1 timer bit is no level", 1'b0, 9'h0);
   endtask

   task automatic t_disable();
      set_lv(16'h8000, '0, 4'd0, 1'b0); tick();
      chk_out("R6 disabled", 1'b0, 9'h0);
      glb_en = 1'b1; tick();
      chk_out("R6 enabled again", 1'b1, 9'h04F);
   endtask

   task automatic t_nest();
      trap_lvl = 3'd0; act_tt = 9'h04D;
      set_lv(16'h0200, '0, 4'd0, 1'b1); tick();
      chk_out("R7 tl zero no hold", 1'b1, 9'h049);
      trap_lvl = 3'd1; lvl_ext = 16'h0400; tick();
      chk_out("R7 held by higher active", 1'b1, 9'h049);
      lvl_ext = 16'h8000; tick();
      chk_out("R7 new above active", 1'b1, 9'h04F);
      lvl_ext = 16'h0400; act_tt = 9'h060; tick();
      chk_out("R7 active outside group", 1'b1, 9'h04A);
      act_tt = 9'h04A; tick();
      chk_out("R7 equal active", 1'b1, 9'h04A);
      act_tt = 9'h04D; lvl_ext = 16'h0000; tick();
      chk_out("R7 nothing pending clears", 1'b0, 9'h0);
      lvl_ext = 16'h0400; tick();
      chk_out("R7 held at cleared", 1'b0, 9'h0);
      trap_lvl = 3'd0; act_tt = 9'h0; lvl_ext = '0; tick();
   endtask

   task automatic t_vector();
      set_lv(16'h8000, '0, 4'd0, 1'b1);
      vec_raise = 1; vec_src = 6'h13; tick();
      vec_raise = 0;
      chk_out("R5 vector over level 15", 1'b1, 9'h060);
      chk_data("R8 raise data", 64'h7D3);
      glb_en = 1'b0; pil = 4'd15; tick();
      chk_out("R5 vector when disabled", 1'b1, 9'h060);
      vec_raise = 1; vec_src = 6'h02; tick();
      vec_raise = 0;
      chk_data("R9 second raise ignored", 64'h7D3);
      chk_out("R9 still vector", 1'b1, 9'h060);
      set_lv(16'h8000, '0, 4'd0, 1'b1);
      vec_lower = 1; tick();
      vec_lower = 0;
      chk_out("R10 lower falls to level 15", 1'b1, 9'h04F);
      chk_data("R10 data kept", 64'h7D3);
      lvl_ext = '0; tick();
      chk_out("R10 idle", 1'b0, 9'h0);
      vec_raise = 1; vec_lower = 1; vec_src = 6'h05; tick();
      vec_raise = 0; vec_lower = 0;
      chk_out("R11 lower wins", 1'b0, 9'h0);
      chk_data("R11 data kept", 64'h7D3);
      vec_raise = 1; vec_src = 6'h3F; tick();
      vec_raise = 0;
      chk_data("R8 max source", 64'h7FF);
      rst = 1'b1; tick();
      rst = 1'b0;
      chk_out("R12 reset mid run", 1'b0, 9'h0);
      chk_data("R12 reset mid run", 64'h0);
      tick();
      chk_out("R12 pending cleared", 1'b0, 9'h0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_levels();
      t_timers();
      t_disable();
      t_nest();
      t_vector();
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule